// File: doc/BRIEF.md
# Sequential Two-Share Masked AND

This block forms the bitwise AND of two secret operands that arrive in Boolean-masked form. Each operand is given as two shares whose XOR is the true value, so no wire ever carries the plain operand. The block also takes one fresh random word per operation. It returns the result as two shares, `y0` and `y1`, whose XOR is the AND of the two hidden operands.

A single-cycle AND of the recombined operands would expose the secret in one combinational cone. This block avoids that. It seeds both output shares with the random word and then walks the four cross-share products one at a time. Each product is first captured in a temporary register and then XORed into `y1` in a separate registered step. Between products the temporary register returns to zero. Because of this, no register ever switches directly from one product to another product that shares an operand share.

A caller raises `start` for one cycle while the block is idle, with operand shares and the random word valid in that cycle. It then waits for the one-cycle `done` pulse and reads `y0` and `y1`.

Top module: `masked_and_seq`

## Requirements
- R1: While reset is held and right after it is released, `done` and `busy` are 0 and `y0` and `y1` are all zeros.
- R2: A `start` seen in the idle state loads both `y0` and `y1` with the `rnd` value present at that edge.
- R3: `rnd` is sampled only at the start edge. `y0` then keeps that value until the next accepted start, whatever `rnd` does in between.
- R4: When `done` is 1, `y0 ^ y1` equals `(a0 ^ a1) & (b0 ^ b1)` for the operand shares sampled at the start edge, for every width-`WIDTH` input.
- R5: The partial products are folded into `y1` in this order: a0&b0, a1&b0, a0&b1, a1&b1. After the 2nd, 4th, 6th and 8th edge following the start edge, `y1` equals the random word XORed with the first 1, 2, 3 and 4 products.
- R6: The temporary product register holds zero at every cycle in which a new product is about to be written into it. As a result, `y1` does not change on any edge that forms a product.
- R7: `done` rises on the 8th rising edge after the start edge and stays high for exactly one cycle. `busy` is 1 from the edge after the start edge until `done` falls, and `done` stays 0 before that 8th edge.
- R8: A `start` pulse, or any change of the operand shares, while `busy` is 1 has no effect. The running operation ends on schedule with the result of the operands sampled at its start.
- R9: Operand and random width is the parameter `WIDTH` (default 32).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| a0 | input | WIDTH | First share of operand a |
| a1 | input | WIDTH | Second share of operand a |
| b0 | input | WIDTH | First share of operand b |
| b1 | input | WIDTH | Second share of operand b |
| rnd | input | WIDTH | Fresh random word, sampled at the start edge |
| y0 | output | WIDTH | First result share (equals the random word) |
| y1 | output | WIDTH | Second result share |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result shares are final |

## Verification
The recombined result is checked against a plain AND for several pattern families. All-zero and all-one shares show that each product reaches `y1` with the right polarity. Walking and alternating bit patterns with unequal shares expose a swapped or duplicated share index, because each product then differs. Pseudo-random shares cover general bit mixing. Intermediate `y1` values after each fold pin the product order. Perturbing `rnd`, the operands and `start` in mid-operation separates correct sampling from late sampling.

// File: rtl/mand_pkg.sv
package mand_pkg;
  localparam int NUM_PROD = 4;
  localparam int STEP_W   = $clog2(NUM_PROD);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROD = 2'd1,
    ST_FOLD = 2'd2,
    ST_DONE = 2'd3
  } mand_state_t;

  // Step index bit 0 picks the a-share, bit 1 picks the b-share:
  // step 0: a0&b0, 1: a1&b0, 2: a0&b1, 3: a1&b1.
  function automatic logic a_pick(input logic [STEP_W-1:0] step);
    return step[0];
  endfunction

  function automatic logic b_pick(input logic [STEP_W-1:0] step);
    return step[1];
  endfunction
endpackage

// File: rtl/mand_seq.sv
module mand_seq
  import mand_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              load_en,
  output logic              prod_en,
  output logic              fold_en,
  output logic [STEP_W-1:0] step,
  output logic              busy,
  output logic              done
);
  mand_state_t       state_q, state_d;
  logic [STEP_W-1:0] step_q;
  logic              last_step;
  logic              done_q;

  assign last_step = (step_q == STEP_W'(NUM_PROD-1));
  assign load_en   = (state_q == ST_IDLE) && start;
  assign prod_en   = (state_q == ST_PROD);
  assign fold_en   = (state_q == ST_FOLD);
  assign step      = step_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_PROD;
      ST_PROD: state_d = ST_FOLD;
      ST_FOLD: state_d = last_step ? ST_DONE : ST_PROD;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fold_en && last_step;
      if (load_en)
        step_q <= '0;
      else if (fold_en)
        step_q <= step_q + 1'b1;
    end
  end

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: done only follows the fold of the last product
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(fold_en) && $past(step_q) == STEP_W'(NUM_PROD-1));

  // R8: no new operation can be accepted while busy
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load_en);
endmodule

// File: rtl/mand_prod.sv
module mand_prod
  import mand_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              prod_en,
  input  logic              fold_en,
  input  logic [STEP_W-1:0] step,
  input  logic [WIDTH-1:0]  a0,
  input  logic [WIDTH-1:0]  a1,
  input  logic [WIDTH-1:0]  b0,
  input  logic [WIDTH-1:0]  b1,
  output logic [WIDTH-1:0]  tmp,
  output logic [WIDTH-1:0]  a_held [2],
  output logic [WIDTH-1:0]  b_held [2]
);
  logic [WIDTH-1:0] a_in [2];
  logic [WIDTH-1:0] b_in [2];
  logic [WIDTH-1:0] a_sh [2];
  logic [WIDTH-1:0] b_sh [2];
  logic [WIDTH-1:0] tmp_q;
  logic [WIDTH-1:0] prod_d;

  assign a_in[0] = a0;
  assign a_in[1] = a1;
  assign b_in[0] = b0;
  assign b_in[1] = b1;

  for (genvar s = 0; s < 2; s++) begin : g_share
    always_ff @(posedge clk) begin
      if (rst) begin
        a_sh[s] <= '0;
        b_sh[s] <= '0;
      end else if (load_en) begin
        a_sh[s] <= a_in[s];
        b_sh[s] <= b_in[s];
      end
    end
    assign a_held[s] = a_sh[s];
    assign b_held[s] = b_sh[s];
  end

  // Only one registered share pair feeds this cone in any cycle.
  assign prod_d = a_sh[a_pick(step)] & b_sh[b_pick(step)];

  always_ff @(posedge clk) begin
    if (rst)
      tmp_q <= '0;
    else if (load_en || fold_en)
      tmp_q <= '0;
    else if (prod_en)
      tmp_q <= prod_d;
  end

  assign tmp = tmp_q;

  // R6: the temporary register is zero whenever a new product is written
  p_tmp_zero_before_prod_r6: assert property (@(posedge clk) disable iff (rst)
    prod_en |-> tmp_q == '0);

  // R8: held operand shares change only at an accepted start
  p_ops_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(a_sh[0]) && $stable(a_sh[1]) &&
                 $stable(b_sh[0]) && $stable(b_sh[1]));
endmodule

// File: rtl/mand_acc.sv
module mand_acc #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             prod_en,
  input  logic             fold_en,
  input  logic [WIDTH-1:0] rnd,
  input  logic [WIDTH-1:0] tmp,
  output logic [WIDTH-1:0] y0,
  output logic [WIDTH-1:0] y1
);
  logic [WIDTH-1:0] y0_q;
  logic [WIDTH-1:0] y1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      y0_q <= '0;
      y1_q <= '0;
    end else if (load_en) begin
      y0_q <= rnd;
      y1_q <= rnd;
    end else if (fold_en) begin
      y1_q <= y1_q ^ tmp;
    end
  end

  assign y0 = y0_q;
  assign y1 = y1_q;

  // R3: y0 keeps the drawn random word between accepted starts
  p_y0_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(y0_q));

  // R6: a product-forming edge leaves y1 untouched
  p_y1_quiet_prod_r6: assert property (@(posedge clk) disable iff (rst)
    prod_en |=> $stable(y1_q));
endmodule

// File: rtl/masked_and_seq.sv
module masked_and_seq
  import mand_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] a0,
  input  logic [WIDTH-1:0] a1,
  input  logic [WIDTH-1:0] b0,
  input  logic [WIDTH-1:0] b1,
  input  logic [WIDTH-1:0] rnd,
  output logic [WIDTH-1:0] y0,
  output logic [WIDTH-1:0] y1,
  output logic             busy,
  output logic             done
);
  logic              load_en, prod_en, fold_en;
  logic [STEP_W-1:0] step;
  logic [WIDTH-1:0]  tmp;
  logic [WIDTH-1:0]  a_held [2];
  logic [WIDTH-1:0]  b_held [2];

  mand_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .load_en (load_en),
    .prod_en (prod_en),
    .fold_en (fold_en),
    .step    (step),
    .busy    (busy),
    .done    (done)
  );

  mand_prod #(.WIDTH(WIDTH)) u_prod (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .prod_en (prod_en),
    .fold_en (fold_en),
    .step    (step),
    .a0      (a0),
    .a1      (a1),
    .b0      (b0),
    .b1      (b1),
    .tmp     (tmp),
    .a_held  (a_held),
    .b_held  (b_held)
  );

  mand_acc #(.WIDTH(WIDTH)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .prod_en (prod_en),
    .fold_en (fold_en),
    .rnd     (rnd),
    .tmp     (tmp),
    .y0      (y0),
    .y1      (y1)
  );

  // R4: recombined output equals the AND of the recombined held operands
  p_result_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (y0 ^ y1) == ((a_held[0] ^ a_held[1]) & (b_held[0] ^ b_held[1])));
endmodule

// File: tb/tb_masked_and_seq.sv
module tb_masked_and_seq;
  localparam int W = 32;
  localparam int NV = 6;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [W-1:0] a0, a1, b0, b1, rnd;
  logic [W-1:0] y0, y1;
  logic         busy, done;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  masked_and_seq #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .start(start),
    .a0(a0), .a1(a1), .b0(b0), .b1(b1), .rnd(rnd),
    .y0(y0), .y1(y1), .busy(busy), .done(done)
  );

  // Each entry: {a0, a1, b0, b1, rnd}
  localparam logic [5*W-1:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h1234_5678},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hA5A5_A5A5},
    {32'hAAAA_AAAA, 32'h5555_5555, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'hDEAD_BEEF},
    {32'h0000_0001, 32'h8000_0000, 32'h8000_0001, 32'h0000_FFFF, 32'hFFFF_FFFF},
    {32'h1357_9BDF, 32'h2468_ACE0, 32'hCAFE_F00D, 32'h0BAD_CAFE, 32'h7777_0000}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation; perturbs inputs mid-way when disturb is set.
  task automatic run_op(input logic [W-1:0] ia0, ia1, ib0, ib1, id, input bit disturb);
    logic [W-1:0] acc;
    logic [W-1:0] p [4];
    p[0] = ia0 & ib0; p[1] = ia1 & ib0; p[2] = ia0 & ib1; p[3] = ia1 & ib1;
    @(negedge clk);
    a0 = ia0; a1 = ia1; b0 = ib0; b1 = ib1; rnd = id; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 y0 load", y0, id);
    chk("R2 y1 load", y1, id);
    chk("R7 busy", {31'b0, busy}, 32'd1);
    acc = id;
    for (int e = 1; e <= 8; e++) begin
      if (disturb) begin
        rnd = ~rnd; a0 = ~a0; b1 = b1 ^ 32'h0F0F_0F0F;
        start = (e == 3);
      end
      @(negedge clk);
      if (e % 2 == 0) begin
        acc = acc ^ p[e/2 - 1];
        chk("R5 y1 fold", y1, acc);
      end else begin
        chk("R6 y1 quiet", y1, acc);
      end
      if (e < 8) chk("R7 done early", {31'b0, done}, 32'd0);
    end
    start = 1'b0;
    chk("R7 done", {31'b0, done}, 32'd1);
    chk("R4 result", y0 ^ y1, (ia0 ^ ia1) & (ib0 ^ ib1));
    chk("R3 y0 held", y0, id);
    @(negedge clk);
    chk("R7 done drop", {31'b0, done}, 32'd0);
    chk("R7 busy drop", {31'b0, busy}, 32'd0);
    chk("R8 idle after", {31'b0, busy}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0;
    a0 = '0; a1 = '0; b0 = '0; b1 = '0; rnd = '0;
    repeat (3) @(negedge clk);
    chk("R1 y0 in reset", y0, '0);
    chk("R1 done in reset", {31'b0, done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 y1 after reset", y1, '0);
    chk("R1 busy after reset", {31'b0, busy}, 32'd0);

    // R4 R5 table of vectors (R9: full 32-bit width)
    for (int i = 0; i < NV; i++)
      run_op(VEC[i][5*W-1:4*W], VEC[i][4*W-1:3*W], VEC[i][3*W-1:2*W],
             VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0);

    // R3 R8: inputs and start toggled during the operation
    run_op(32'hC3C3_1111, 32'h0F0F_2222, 32'h3C3C_4444, 32'hF00F_8888, 32'h5A5A_5A5A, 1'b1);

    // R4: pseudo-random shares
    for (int k = 0; k < 20; k++)
      run_op($urandom, $urandom, $urandom, $urandom, $urandom, (k % 4) == 0);

    // R8: start held high through the done cycle; the next start must wait for idle
    @(negedge clk);
    a0 = 32'hFFFF_0000; a1 = '0; b0 = 32'h00FF_00FF; b1 = '0; rnd = 32'h1111_1111; start = 1'b1;
    repeat (9) @(negedge clk);
    chk("R7 done with start held", {31'b0, done}, 32'd1);
    chk("R8 result with start held", y0 ^ y1, 32'h00FF_0000);
    start = 1'b0;
    @(negedge clk);
    chk("R8 back to idle", {31'b0, busy}, 32'd0);

    // R1: reset mid-operation clears state
    run_op(32'h1, 32'h2, 32'h3, 32'h0, 32'h9, 1'b0);
    @(negedge clk);
    a0 = 32'h7; rnd = 32'hABCD_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 y0 after mid reset", y0, '0);
    chk("R1 busy after mid reset", {31'b0, busy}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule